// File: doc/BRIEF.md
# Lock-Guarded Coherent Shared Memory

The block gives a group of requesters a coherent shared memory built on top of an incoherent one. Each requester owns a private view of every word. A view entry carries a live bit, which says it holds a copy, and a dirty bit, which says its copy is newer than the global store. These views are never kept in step with each other by the memory itself. Coherence comes from a single exclusive lock. Reads and writes are honoured only for the requester that holds the lock. Taking the lock and giving it back are each paired with a barrier sweep over the taker's view. The sweep copies every dirty word back to the global store and then empties the view.

A requester opens a critical section with an acquire and closes it with a release. Between the two it reads and writes freely. A read of a word that is not live in the view first copies the global value into the view. A write lands only in the view and marks the word dirty. Because every critical section starts and ends with an empty view, the next holder always finds the last committed value in the global store.

All requests share one engine, so at most one request is accepted per cycle. A requester holds its request until it is accepted and then receives exactly one response. Acquires that arrive while the lock is taken are not accepted; they wait without blocking other requesters.

Top module: `lockgate_mem`

## Requirements
- R1: After reset no lock is held, every view is empty, every global word reads as zero, and no response or acceptance is asserted while no request is presented.
- R2: A read by the lock holder returns the value most recently written by any earlier holder. Values from an earlier critical section of the same requester are never returned in place of a newer one.
- R3: A write by the lock holder gets a response without error. A later read of the same word by the same holder, in the same critical section, returns the written value.
- R4: A read or write from a requester that does not hold the lock gets an error response. It changes neither the lock nor any stored value.
- R5: An acquire is accepted only while no requester holds the lock, and it grants the lock to that requester. An acquire presented while the lock is held stays unaccepted, with its acceptance low, until the holder's release has completed.
- R6: When several requests can be accepted in the same cycle, the lowest-numbered requester wins, and at most one request is accepted per cycle.
- R7: A release by the holder writes every dirty view word back to the global store, empties the view, then frees the lock and responds without error. A release from a non-holder gets an error response and leaves the lock unchanged.
- R8: Every accepted request gets exactly one response, to its own requester. A read, write or rejected request responds in the cycle after acceptance. An accepted acquire or holder release responds DEPTH+1 cycles after acceptance. Operation codes on each 2-bit op field are: 00 read, 01 write, 10 acquire, 11 release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request present, one bit per requester, held until accepted |
| req_op_i | input | 2*N_REQ | Operation code per requester, requester i at bits [2i+1:2i] |
| req_addr_i | input | N_REQ*AW | Word address per requester |
| req_wdata_i | input | N_REQ*DW | Write data per requester |
| req_ready_o | output | N_REQ | Request accepted this cycle (one-hot or zero) |
| rsp_valid_o | output | N_REQ | Response present for the indicated requester (one-hot or zero) |
| rsp_err_o | output | 1 | Response reports a rejected request |
| rsp_rdata_o | output | DW | Read data of a successful read response |

## Verification
The bench builds the block with three requesters, a four-word store and 8-bit data. With only four words, the barrier sweep is short enough that the DEPTH+1 cycle latency can be counted exactly. Every word of the store can also be dirtied and then seen again by another requester. Three requesters let the bench hold the lock with one of them and have two others contend for it at the same time. That exercises the fixed priority, the parked acquire and the rejection of non-holders side by side.

// File: rtl/lockgate_pkg.sv
package lockgate_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_ACQUIRE = 2'b10,
    OP_RELEASE = 2'b11
  } op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } eng_state_e;

endpackage

// File: rtl/lockgate_arb.sv
module lockgate_arb #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // blocked[i]: some lower index is requesting
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i]     = req_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req_i[i];
  end

  assign any_o = blocked[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/lockgate_view.sv
module lockgate_view #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          fill_i,
  input  logic          write_i,
  input  logic          drop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          live_o,
  output logic          dirty_o
);

  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] live_q;
  logic [DEPTH-1:0] dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= '0;
      dirty_q <= '0;
    end else if (drop_i) begin
      live_q[addr_i]  <= 1'b0;
      dirty_q[addr_i] <= 1'b0;
    end else if (fill_i) begin
      live_q[addr_i]  <= 1'b1;
    end else if (write_i) begin
      live_q[addr_i]  <= 1'b1;
      dirty_q[addr_i] <= 1'b1;
    end
  end

  // payload needs no reset: only read while live
  always_ff @(posedge clk_i) begin
    if (!drop_i && (fill_i || write_i)) data_q[addr_i] <= wdata_i;
  end

  assign rdata_o = data_q[addr_i];
  assign live_o  = live_q[addr_i];
  assign dirty_o = dirty_q[addr_i];

endmodule

// File: rtl/lockgate_gmem.sv
module lockgate_gmem #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/lockgate_mem.sv
module lockgate_mem
  import lockgate_pkg::*;
#(
  parameter  int N_REQ = 4,
  parameter  int DEPTH = 16,
  parameter  int DW    = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_REQ-1:0]    req_valid_i,
  input  logic [2*N_REQ-1:0]  req_op_i,
  input  logic [N_REQ*AW-1:0] req_addr_i,
  input  logic [N_REQ*DW-1:0] req_wdata_i,
  output logic [N_REQ-1:0]    req_ready_o,
  output logic [N_REQ-1:0]    rsp_valid_o,
  output logic                rsp_err_o,
  output logic [DW-1:0]       rsp_rdata_o
);

  localparam logic [N_REQ-1:0] ONE_HOT0 = N_REQ'(1);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  eng_state_e       state_q;
  logic             lock_q;
  logic [IW-1:0]    owner_q;
  logic [AW-1:0]    sweep_q;
  logic             sweep_rel_q;
  logic [N_REQ-1:0] rsp_valid_q;
  logic             rsp_err_q;
  logic [DW-1:0]    rsp_rdata_q;

  op_e           op_a    [N_REQ];
  logic [AW-1:0] addr_a  [N_REQ];
  logic [DW-1:0] wdata_a [N_REQ];
  logic [N_REQ-1:0] eligible;

  for (genvar i = 0; i < N_REQ; i++) begin : g_unpack
    assign op_a[i]     = op_e'(req_op_i[2*i +: 2]);
    assign addr_a[i]   = req_addr_i[AW*i +: AW];
    assign wdata_a[i]  = req_wdata_i[DW*i +: DW];
    // an acquire parks while the lock is taken
    assign eligible[i] = req_valid_i[i] && !(lock_q && op_a[i] == OP_ACQUIRE);
  end

  logic [N_REQ-1:0] gnt;
  logic [IW-1:0]    gidx;
  logic             gany;

  lockgate_arb #(.N(N_REQ)) u_arb (
    .req_i (state_q == ST_IDLE ? eligible : '0),
    .gnt_o (gnt),
    .idx_o (gidx),
    .any_o (gany)
  );

  assign req_ready_o = gnt;

  op_e           g_op;
  logic [AW-1:0] g_addr;
  logic [DW-1:0] g_wdata;
  logic          holder;

  assign g_op    = op_a[gidx];
  assign g_addr  = addr_a[gidx];
  assign g_wdata = wdata_a[gidx];
  assign holder  = lock_q && (owner_q == gidx);

  logic          sweeping;
  logic [IW-1:0] act_idx;
  logic [AW-1:0] act_addr;

  assign sweeping = (state_q == ST_SWEEP);
  assign act_idx  = sweeping ? owner_q : gidx;
  assign act_addr = sweeping ? sweep_q : g_addr;

  logic [DW-1:0] v_rdata [N_REQ];
  logic [N_REQ-1:0] v_live;
  logic [N_REQ-1:0] v_dirty;
  logic [DW-1:0] act_data;
  logic          act_live;
  logic          act_dirty;
  logic [DW-1:0] gm_rdata;

  assign act_data  = v_rdata[act_idx];
  assign act_live  = v_live[act_idx];
  assign act_dirty = v_dirty[act_idx];

  logic do_read;
  logic do_fill;
  logic do_write;
  logic gm_we;

  assign do_read  = gany && g_op == OP_READ && holder;
  assign do_fill  = do_read && !act_live && !act_dirty;
  assign do_write = gany && g_op == OP_WRITE && holder;
  assign gm_we    = sweeping && act_dirty;

  for (genvar i = 0; i < N_REQ; i++) begin : g_view
    logic sel;
    assign sel = (act_idx == IW'(i));

    lockgate_view #(.DEPTH(DEPTH), .DW(DW)) u_view (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .addr_i  (act_addr),
      .fill_i  (sel && do_fill),
      .write_i (sel && do_write),
      .drop_i  (sel && sweeping),
      .wdata_i (do_fill ? gm_rdata : g_wdata),
      .rdata_o (v_rdata[i]),
      .live_o  (v_live[i]),
      .dirty_o (v_dirty[i])
    );
  end

  lockgate_gmem #(.DEPTH(DEPTH), .DW(DW)) u_gmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (act_addr),
    .we_i    (gm_we),
    .wdata_i (act_data),
    .rdata_o (gm_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lock_q      <= 1'b0;
      owner_q     <= '0;
      sweep_q     <= '0;
      sweep_rel_q <= 1'b0;
      rsp_valid_q <= '0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= '0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (gany) begin
            unique case (g_op)
              OP_ACQUIRE: begin
                // lock first, barrier as a following step
                lock_q      <= 1'b1;
                owner_q     <= gidx;
                state_q     <= ST_SWEEP;
                sweep_q     <= '0;
                sweep_rel_q <= 1'b0;
              end
              OP_RELEASE: begin
                if (holder) begin
                  state_q     <= ST_SWEEP;
                  sweep_q     <= '0;
                  sweep_rel_q <= 1'b1;
                end else begin
                  rsp_valid_q <= gnt;
                  rsp_err_q   <= 1'b1;
                end
              end
              OP_READ: begin
                rsp_valid_q <= gnt;
                rsp_err_q   <= !holder;
                if (holder) rsp_rdata_q <= act_live ? act_data : gm_rdata;
              end
              default: begin
                rsp_valid_q <= gnt;
                rsp_err_q   <= !holder;
              end
            endcase
          end
        end
        default: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == LAST_IDX) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= ONE_HOT0 << owner_q;
            // barrier done before the lock is freed
            if (sweep_rel_q) lock_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;

endmodule

// File: rtl/lockgate_mem_chk.sv
module lockgate_mem_chk #(
  parameter  int N_REQ = 4,
  localparam int IW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_REQ-1:0]   req_valid_i,
  input logic [2*N_REQ-1:0] req_op_i,
  input logic [N_REQ-1:0]   req_ready_i,
  input logic [N_REQ-1:0]   rsp_valid_i,
  input logic               rsp_err_i,
  input logic               lock_i,
  input logic [IW-1:0]      owner_i
);

  logic [N_REQ-1:0] acq_vec;
  logic [N_REQ-1:0] rdwr_vec;

  for (genvar i = 0; i < N_REQ; i++) begin : g_dec
    assign acq_vec[i]  = req_valid_i[i] && req_op_i[2*i +: 2] == 2'b10;
    assign rdwr_vec[i] = req_valid_i[i] && !req_op_i[2*i+1];
  end

  p_one_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_i));

  p_one_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_i));

  p_rdwr_next_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_ready_i & rdwr_vec)) |=> (rsp_valid_i == $past(req_ready_i)));

  p_acq_parked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lock_i && |(acq_vec & req_ready_i)));

  p_lock_from_acq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> $past(|(acq_vec & req_ready_i)));

  p_err_keeps_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_i |-> ($stable(lock_i) && $stable(owner_i)));

  p_release_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_i) |-> ((|rsp_valid_i) && !rsp_err_i));

endmodule

bind lockgate_mem lockgate_mem_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_ready_i (req_ready_o),
  .rsp_valid_i (rsp_valid_o),
  .rsp_err_i   (rsp_err_o),
  .lock_i      (lock_q),
  .owner_i     (owner_q)
);

// File: tb/tb_lockgate_mem.sv
module tb_lockgate_mem;

  localparam int N  = 3;
  localparam int DP = 4;
  localparam int DW = 8;
  localparam int AW = 2;

  localparam logic [1:0] RD = 2'b00;
  localparam logic [1:0] WR = 2'b01;
  localparam logic [1:0] AQ = 2'b10;
  localparam logic [1:0] RL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          v   [N];
  logic [1:0]    opv [N];
  logic [AW-1:0] adv [N];
  logic [DW-1:0] wdv [N];

  logic [N-1:0]    req_valid;
  logic [2*N-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    req_ready;
  logic [N-1:0]    rsp_valid;
  logic            rsp_err;
  logic [DW-1:0]   rsp_rdata;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]           = v[i];
      req_op[2*i +: 2]       = opv[i];
      req_addr[AW*i +: AW]   = adv[i];
      req_wdata[DW*i +: DW]  = wdv[i];
    end
  end

  lockgate_mem #(.N_REQ(N), .DEPTH(DP), .DW(DW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .req_ready_o (req_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_err_o   (rsp_err),
    .rsp_rdata_o (rsp_rdata)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input int p, input logic [1:0] o, input int a,
                       input logic [DW-1:0] d, output logic err,
                       output logic [DW-1:0] rdat, output int lat);
    int t0;
    @(negedge clk);
    v[p] = 1'b1; opv[p] = o; adv[p] = AW'(a); wdv[p] = d;
    #1;
    while (!req_ready[p]) begin
      @(negedge clk);
      #1;
    end
    t0 = cyc;
    @(posedge clk);
    #1;
    v[p] = 1'b0;
    forever begin
      @(negedge clk);
      if (rsp_valid[p]) break;
    end
    err  = rsp_err;
    rdat = rsp_rdata;
    lat  = cyc - t0;
  endtask

  typedef struct packed {
    logic [1:0] p;
    logic [1:0] op;
    logic [1:0] a;
    logic [7:0] d;
    logic       err;
    logic       chk;
    logic [7:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, RD, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 read without lock
    '{2'd0, WR, 2'd1, 8'h55, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 write without lock
    '{2'd0, AQ, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5},  // R5
    '{2'd0, RD, 2'd1, 8'h00, 1'b0, 1'b1, 8'h00, 4'd1},  // R1 store starts at zero
    '{2'd0, WR, 2'd1, 8'h5A, 1'b0, 1'b0, 8'h00, 4'd3},  // R3
    '{2'd0, RD, 2'd1, 8'h00, 1'b0, 1'b1, 8'h5A, 4'd3},  // R3
    '{2'd1, WR, 2'd1, 8'h77, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 non-holder
    '{2'd1, RD, 2'd1, 8'h00, 1'b1, 1'b0, 8'h00, 4'd4},  // R4 non-holder
    '{2'd1, RL, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd7},  // R7 non-holder release
    '{2'd0, RD, 2'd1, 8'h00, 1'b0, 1'b1, 8'h5A, 4'd4},  // R4 no side effect
    '{2'd0, WR, 2'd3, 8'hC3, 1'b0, 1'b0, 8'h00, 4'd3},  // R3
    '{2'd0, RL, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7},  // R7
    '{2'd1, AQ, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5},  // R5
    '{2'd1, RD, 2'd1, 8'h00, 1'b0, 1'b1, 8'h5A, 4'd2},  // R2 written back
    '{2'd1, RD, 2'd3, 8'h00, 1'b0, 1'b1, 8'hC3, 4'd2},  // R2
    '{2'd1, WR, 2'd1, 8'h11, 1'b0, 1'b0, 8'h00, 4'd3},  // R3
    '{2'd1, RD, 2'd1, 8'h00, 1'b0, 1'b1, 8'h11, 4'd3},  // R3
    '{2'd1, RL, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7},  // R7
    '{2'd0, AQ, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd5},  // R5
    '{2'd0, RD, 2'd1, 8'h00, 1'b0, 1'b1, 8'h11, 4'd2},  // R2 no stale 5A
    '{2'd0, RL, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd7}   // R7
  };

  initial begin
    logic          e_err;
    logic [DW-1:0] e_dat;
    int            e_lat;
    int            t_a, t_b, t_rel;
    for (int i = 0; i < N; i++) begin
      v[i] = 1'b0; opv[i] = RD; adv[i] = '0; wdv[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == '0, "R1", "response idle after reset", int'(rsp_valid), 0);
    check(req_ready == '0, "R1", "no acceptance without request", int'(req_ready), 0);

    for (int k = 0; k < NV; k++) begin
      vec_t e;
      string tg;
      e  = VEC[k];
      tg = $sformatf("R%0d", e.rq);
      issue(int'(e.p), e.op, int'(e.a), e.d, e_err, e_dat, e_lat);
      check(e_err == e.err, tg, $sformatf("vector %0d error flag", k),
            int'(e_err), int'(e.err));
      if (e.chk)
        check(e_dat == e.exp, tg, $sformatf("vector %0d read data", k),
              int'(e_dat), int'(e.exp));
      check(e_lat == ((!e.err && e.op[1]) ? DP + 1 : 1), "R8",
            $sformatf("vector %0d latency", k), e_lat,
            (!e.err && e.op[1]) ? DP + 1 : 1);
    end

    // R6 and R5: two acquires at once, lower index wins, the other parks
    t_a = 0; t_b = 0; t_rel = 0;
    fork
      begin
        logic          x_err;
        logic [DW-1:0] x_dat;
        int            x_lat;
        issue(1, AQ, 0, 8'h00, x_err, x_dat, x_lat);
        t_a = cyc;
        check(!x_err, "R6", "priority acquire ok", int'(x_err), 0);
        issue(1, WR, 0, 8'h9E, x_err, x_dat, x_lat);
        @(negedge clk);
        check(req_ready[2] == 1'b0, "R5", "parked acquire not accepted",
              int'(req_ready[2]), 0);
        issue(1, RL, 0, 8'h00, x_err, x_dat, x_lat);
        t_rel = cyc;
      end
      begin
        logic          y_err;
        logic [DW-1:0] y_dat;
        int            y_lat;
        issue(2, AQ, 0, 8'h00, y_err, y_dat, y_lat);
        t_b = cyc;
        check(!y_err, "R5", "parked acquire granted later", int'(y_err), 0);
      end
    join
    check(t_a < t_b, "R6", "lower index acquired first", t_b, t_a + 1);
    check(t_b > t_rel, "R5", "second acquire after release", t_b, t_rel + 1);
    issue(2, RD, 0, 8'h00, e_err, e_dat, e_lat);
    check(e_dat == 8'h9E, "R2", "new holder sees prior commit", int'(e_dat), 'h9E);
    issue(0, WR, 2, 8'h44, e_err, e_dat, e_lat);
    check(e_err == 1'b1, "R4", "write by non-holder while other holds", int'(e_err), 1);
    issue(2, RD, 2, 8'h00, e_err, e_dat, e_lat);
    check(e_dat == 8'h00, "R4", "rejected write left store", int'(e_dat), 0);
    issue(2, RL, 0, 8'h00, e_err, e_dat, e_lat);
    check(!e_err && e_lat == DP + 1, "R7", "final release", e_lat, DP + 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule